// File: doc/BRIEF.md
# SIMT Warp Reconvergence Stack

This block follows the control flow of one warp whose threads run in lockstep across SIMD lanes. It holds a small stack. Each entry has a next PC, a reconvergence PC and a lane mask. The top entry gives the pipeline its fetch PC and the set of lanes that may execute. The bottom entry is the base of the warp: it has a full mask and no reconvergence point.

The pipeline reports two kinds of event:

- A **resolved branch** carries a per-lane taken mask, the taken target, the fall-through PC and the branch's immediate post-dominator, which is its reconvergence PC.
- An **advance** carries the next sequential PC.

A branch that splits the active lanes parks the current entry at the reconvergence PC. It then pushes one entry per path, and the not-taken path runs first. A path ends when its PC reaches its reconvergence PC. Its entry is then popped, and the entry below resumes.

The block does not fetch instructions, evaluate branches or compute post-dominators. Lane i is bit i of every mask.

Top module: `simt_reconv_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stack holds only the base entry, so after that edge `fetch_pc` is `RESET_PC`, `active_mask` is all ones and `overflow` is 0.
- R2: An advance with no branch in the same cycle sets the top PC to `adv_pc`, unless R5 applies. A cycle with neither event changes neither output.
- R3: A branch is divergent when the effective taken mask, `br_taken & active_mask`, is neither zero nor equal to `active_mask`. On a divergent branch the top entry's PC becomes `br_reconv`. A taken-path entry is then pushed (target, taken lanes), followed by a not-taken entry (fall-through, remaining active lanes), both tagged with `br_reconv`. Fetch continues at the fall-through PC under the not-taken lanes.
- R4: A branch whose effective taken mask is zero moves the top PC to `br_fallthru`. One whose effective taken mask equals `active_mask` moves it to `br_target`. Neither pushes an entry. Lanes set in `br_taken` but outside `active_mask` have no effect.
- R5: When a PC written to a non-base top entry equals that entry's reconvergence PC, the entry is popped. Fetch resumes with the PC and mask stored in the entry below.
- R6: On a divergent branch whose `br_reconv` equals the top entry's reconvergence PC, the top entry is replaced by the new path entries instead of being kept. After both paths finish, fetch continues under the mask of the entry below.
- R7: A path whose start PC equals `br_reconv` is not pushed. Its lanes wait in the parked entry.
- R8: If a divergent branch needs more than `DEPTH` entries, the stack and outputs are left unchanged. `overflow` is set and stays 1 until reset.
- R9: When a branch and an advance arrive in the same cycle, the branch is applied and the advance is ignored.
- R10: `active_mask` is never all zeros outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | Branch resolved this cycle |
| br_taken | input | LANES | Per-lane taken mask |
| br_target | input | PC_W | Taken-path PC |
| br_fallthru | input | PC_W | Not-taken-path PC |
| br_reconv | input | PC_W | Reconvergence PC of the branch |
| adv_valid | input | 1 | Sequential PC advance this cycle |
| adv_pc | input | PC_W | Next sequential PC |
| fetch_pc | output | PC_W | PC of the top entry |
| active_mask | output | LANES | Lane mask of the top entry |
| overflow | output | 1 | Sticky stack-overflow flag |

## Verification
The checker checks the following on every cycle:

- The reset state.
- A non-empty active mask.
- Idle cycles leaving fetch state unchanged.
- The stickiness of the overflow flag.
- The landing of a divergent branch on its fall-through path with the not-taken lanes, when the stack has room.
- Branch priority over a simultaneous advance at the base entry.

Some behaviours need whole scenarios, so only the bench's sequences can show them:

- The order in which paths are unwound.
- The resumption of the sibling path after a pop.
- Nested divergence.
- Replacement of a top entry that shares a reconvergence PC.
- Paths that are skipped because they start at the reconvergence point.
- An overflow that leaves state intact.

// File: rtl/simt_stack_pkg.sv
// Shared types for the warp reconvergence stack.
package simt_stack_pkg;
    // Outcome of a resolved branch with respect to the active lanes.
    typedef enum logic [1:0] {
        BR_NONE    = 2'd0,
        BR_UNIFORM = 2'd1,
        BR_DIVERGE = 2'd2
    } br_kind_e;
endpackage

// File: rtl/simt_branch_classify.sv
// Classifies a resolved branch against the active lanes of the top entry.
// It produces the per-path lane masks, the PC taken by a uniform branch,
// which paths need an entry, and whether the top entry can be replaced.
// Assumes act_mask is never zero.
module simt_branch_classify
    import simt_stack_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PC_W  = 32
) (
    input  logic             valid,
    input  logic [LANES-1:0] act_mask,
    input  logic [LANES-1:0] taken_mask,
    input  logic [PC_W-1:0]  target,
    input  logic [PC_W-1:0]  fallthru,
    input  logic [PC_W-1:0]  reconv,
    input  logic [PC_W-1:0]  top_rpc,
    input  logic             top_is_base,
    output br_kind_e         kind,
    output logic [PC_W-1:0]  uni_pc,
    output logic [LANES-1:0] tk_mask,
    output logic [LANES-1:0] nt_mask,
    output logic             push_tk,
    output logic             push_nt,
    output logic             merge
);
    // Split the active lanes and pick the branch outcome.
    always_comb begin
        tk_mask = taken_mask & act_mask;
        nt_mask = act_mask & ~taken_mask;
        uni_pc  = fallthru;
        kind    = BR_NONE;
        if (valid) begin
            if (tk_mask == '0) begin
                kind   = BR_UNIFORM;
                uni_pc = fallthru;
            end else if (tk_mask == act_mask) begin
                kind   = BR_UNIFORM;
                uni_pc = target;
            end else begin
                kind = BR_DIVERGE;
            end
        end
    end

    // A path starting at the reconvergence point needs no entry of its own.
    assign push_tk = (target != reconv);
    assign push_nt = (fallthru != reconv);

    // A top entry that would resume straight at its own reconvergence PC is redundant.
    assign merge = !top_is_base && (reconv == top_rpc);
endmodule

// File: rtl/simt_stack_slot.sv
// One stack entry: next PC, reconvergence PC and lane mask.
// ld_all writes the whole entry and ld_pc only the PC; ld_all has priority.
// Slot zero resets to the base entry, the others to zero.
module simt_stack_slot #(
    parameter int              LANES    = 4,
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RST_PC   = '0,
    parameter bit              RST_FULL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_all,
    input  logic             ld_pc,
    input  logic [PC_W-1:0]  d_pc,
    input  logic [PC_W-1:0]  d_rpc,
    input  logic [LANES-1:0] d_mask,
    output logic [PC_W-1:0]  q_pc,
    output logic [PC_W-1:0]  q_rpc,
    output logic [LANES-1:0] q_mask
);
    // Entry storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_pc   <= RST_FULL ? RST_PC : '0;
            q_rpc  <= '0;
            q_mask <= RST_FULL ? '1 : '0;
        end else if (ld_all) begin
            q_pc   <= d_pc;
            q_rpc  <= d_rpc;
            q_mask <= d_mask;
        end else if (ld_pc) begin
            q_pc <= d_pc;
        end
    end
endmodule

// File: rtl/simt_reconv_stack.sv
// Reconvergence stack for one warp. The top entry drives fetch_pc and
// active_mask.
// - A divergent branch parks the top at the reconvergence PC. It pushes the
//   taken path, then the not-taken path, so the not-taken path runs first.
// - A PC write that reaches the top entry's reconvergence PC pops the entry.
// - A branch has priority over an advance in the same cycle.
// Assumes DEPTH >= 3 and that the caller keeps events low during reset.
module simt_reconv_stack
    import simt_stack_pkg::*;
#(
    parameter int              LANES    = 4,
    parameter int              PC_W     = 32,
    parameter int              DEPTH    = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_fallthru,
    input  logic [PC_W-1:0]  br_reconv,
    input  logic             adv_valid,
    input  logic [PC_W-1:0]  adv_pc,
    output logic [PC_W-1:0]  fetch_pc,
    output logic [LANES-1:0] active_mask,
    output logic             overflow
);
    localparam int SP_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int IDX_W = SP_W + 2;

    logic [SP_W-1:0]  sp_q, sp_d;
    logic             ovf_q, ovf_d;

    logic [PC_W-1:0]  slot_pc   [DEPTH];
    logic [PC_W-1:0]  slot_rpc  [DEPTH];
    logic [LANES-1:0] slot_mask [DEPTH];
    logic             ld_all    [DEPTH];
    logic             ld_pc     [DEPTH];
    logic [PC_W-1:0]  d_pc      [DEPTH];
    logic [PC_W-1:0]  d_rpc     [DEPTH];
    logic [LANES-1:0] d_mask    [DEPTH];

    logic [PC_W-1:0]  top_pc, top_rpc;
    logic [LANES-1:0] top_mask;

    br_kind_e         kind;
    logic [PC_W-1:0]  uni_pc;
    logic [LANES-1:0] tk_mask, nt_mask;
    logic             push_tk, push_nt, merge;

    logic [IDX_W-1:0] base_idx, nt_idx, new_top;
    logic             wr_pc_en;
    logic [PC_W-1:0]  wr_pc;

    // Entry registers; slot zero is the base of the warp.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        simt_stack_slot #(
            .LANES   (LANES),
            .PC_W    (PC_W),
            .RST_PC  (RESET_PC),
            .RST_FULL(g == 0)
        ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .ld_all(ld_all[g]),
            .ld_pc (ld_pc[g]),
            .d_pc  (d_pc[g]),
            .d_rpc (d_rpc[g]),
            .d_mask(d_mask[g]),
            .q_pc  (slot_pc[g]),
            .q_rpc (slot_rpc[g]),
            .q_mask(slot_mask[g])
        );
    end

    // Read the top entry.
    always_comb begin
        top_pc   = slot_pc[0];
        top_rpc  = slot_rpc[0];
        top_mask = slot_mask[0];
        for (int i = 1; i < DEPTH; i++) begin
            if (sp_q == SP_W'(i)) begin
                top_pc   = slot_pc[i];
                top_rpc  = slot_rpc[i];
                top_mask = slot_mask[i];
            end
        end
    end

    simt_branch_classify #(.LANES(LANES), .PC_W(PC_W)) u_classify (
        .valid      (br_valid),
        .act_mask   (top_mask),
        .taken_mask (br_taken),
        .target     (br_target),
        .fallthru   (br_fallthru),
        .reconv     (br_reconv),
        .top_rpc    (top_rpc),
        .top_is_base(sp_q == '0),
        .kind       (kind),
        .uni_pc     (uni_pc),
        .tk_mask    (tk_mask),
        .nt_mask    (nt_mask),
        .push_tk    (push_tk),
        .push_nt    (push_nt),
        .merge      (merge)
    );

    // Slot indices for the entries pushed by a divergent branch.
    always_comb begin
        base_idx = merge ? IDX_W'(sp_q) : IDX_W'(sp_q) + IDX_W'(1);
        nt_idx   = base_idx + IDX_W'(push_tk);
        new_top  = base_idx + IDX_W'(push_tk) + IDX_W'(push_nt) - IDX_W'(1);
    end

    // Decide the PC write, pushes, pops and next stack pointer.
    always_comb begin
        sp_d     = sp_q;
        ovf_d    = ovf_q;
        wr_pc_en = 1'b0;
        wr_pc    = adv_pc;
        for (int i = 0; i < DEPTH; i++) begin
            ld_all[i] = 1'b0;
            ld_pc[i]  = 1'b0;
            d_pc[i]   = br_reconv;
            d_rpc[i]  = br_reconv;
            d_mask[i] = nt_mask;
        end

        case (kind)
            BR_UNIFORM: begin
                wr_pc_en = 1'b1;
                wr_pc    = uni_pc;
            end
            BR_DIVERGE: begin
                if (new_top > IDX_W'(DEPTH - 1)) begin
                    ovf_d = 1'b1;
                end else begin
                    sp_d = SP_W'(new_top);
                    for (int i = 0; i < DEPTH; i++) begin
                        if (!merge && sp_q == SP_W'(i)) begin
                            ld_pc[i] = 1'b1;
                            d_pc[i]  = br_reconv;
                        end
                        if (push_tk && base_idx == IDX_W'(i)) begin
                            ld_all[i] = 1'b1;
                            d_pc[i]   = br_target;
                            d_mask[i] = tk_mask;
                        end
                        if (push_nt && nt_idx == IDX_W'(i)) begin
                            ld_all[i] = 1'b1;
                            d_pc[i]   = br_fallthru;
                            d_mask[i] = nt_mask;
                        end
                    end
                end
            end
            default: begin
                wr_pc_en = adv_valid;
                wr_pc    = adv_pc;
            end
        endcase

        if (wr_pc_en) begin
            if (sp_q != '0 && wr_pc == top_rpc) begin
                sp_d = sp_q - SP_W'(1);
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (sp_q == SP_W'(i)) begin
                        ld_pc[i] = 1'b1;
                        d_pc[i]  = wr_pc;
                    end
                end
            end
        end
    end

    // Stack pointer and sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= '0;
            ovf_q <= 1'b0;
        end else begin
            sp_q  <= sp_d;
            ovf_q <= ovf_d;
        end
    end

    assign fetch_pc    = top_pc;
    assign active_mask = top_mask;
    assign overflow    = ovf_q;
endmodule

// File: rtl/simt_reconv_stack_chk.sv
// Cycle-level properties of the reconvergence stack, bound to the top module.
// Reads the stack pointer to know when a divergent branch has room.
module simt_reconv_stack_chk #(
    parameter int              LANES    = 4,
    parameter int              PC_W     = 32,
    parameter int              DEPTH    = 8,
    parameter int              SP_W     = 3,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             br_valid,
    input logic [LANES-1:0] br_taken,
    input logic [PC_W-1:0]  br_fallthru,
    input logic [PC_W-1:0]  br_reconv,
    input logic             adv_valid,
    input logic [PC_W-1:0]  fetch_pc,
    input logic [LANES-1:0] active_mask,
    input logic             overflow,
    input logic [SP_W-1:0]  sp_q
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (fetch_pc == RESET_PC && active_mask == '1 && !overflow));

    // R10
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && !adv_valid) |=> ($stable(fetch_pc) && $stable(active_mask)));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R3
    diverge_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && (br_taken & active_mask) != '0
         && (br_taken & active_mask) != active_mask
         && br_fallthru != br_reconv && (int'(sp_q) + 2 < DEPTH))
        |=> (fetch_pc == $past(br_fallthru)
             && active_mask == $past(active_mask & ~br_taken)));

    // R9
    branch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && adv_valid && (br_taken & active_mask) == '0 && sp_q == '0)
        |=> fetch_pc == $past(br_fallthru));
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
    .LANES   (LANES),
    .PC_W    (PC_W),
    .DEPTH   (DEPTH),
    .SP_W    (SP_W),
    .RESET_PC(RESET_PC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_valid   (br_valid),
    .br_taken   (br_taken),
    .br_fallthru(br_fallthru),
    .br_reconv  (br_reconv),
    .adv_valid  (adv_valid),
    .fetch_pc   (fetch_pc),
    .active_mask(active_mask),
    .overflow   (overflow),
    .sp_q       (sp_q)
);

// File: tb/tb_simt_reconv_stack.sv
// Scoreboard bench: the driver queues the expected fetch state for each
// event, and the monitor compares it 5 ns after the edge that applies the event.
module tb_simt_reconv_stack;
    localparam int              LANES = 4;
    localparam int              PC_W  = 16;
    localparam int              DEPTH = 4;
    localparam logic [PC_W-1:0] RPC0  = 16'h0100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             br_valid = 1'b0;
    logic [LANES-1:0] br_taken = '0;
    logic [PC_W-1:0]  br_target = '0, br_fallthru = '0, br_reconv = '0;
    logic             adv_valid = 1'b0;
    logic [PC_W-1:0]  adv_pc = '0;
    logic [PC_W-1:0]  fetch_pc;
    logic [LANES-1:0] active_mask;
    logic             overflow;

    typedef struct {
        logic [PC_W-1:0]  pc;
        logic [LANES-1:0] mask;
        logic             ovf;
        string            req;
    } exp_t;

    exp_t expq[$];
    int   n_cmp  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #10 clk = ~clk;

    simt_reconv_stack #(
        .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC(RPC0)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
        .br_fallthru(br_fallthru), .br_reconv(br_reconv),
        .adv_valid(adv_valid), .adv_pc(adv_pc),
        .fetch_pc(fetch_pc), .active_mask(active_mask), .overflow(overflow)
    );

    // Compare the outputs with one expected item.
    task automatic compare(input exp_t e);
        n_cmp++;
        if (fetch_pc !== e.pc || active_mask !== e.mask || overflow !== e.ovf) begin
            n_fail++;
            $display("FAIL %s: pc=%h mask=%b ovf=%b, expected pc=%h mask=%b ovf=%b",
                     e.req, fetch_pc, active_mask, overflow, e.pc, e.mask, e.ovf);
        end
        // R10: the mask is never empty
        n_cmp++;
        if (active_mask == '0) begin
            n_fail++;
            $display("FAIL R10: mask=%b, expected nonzero", active_mask);
        end
    endtask

    // Drive one event at the falling edge and queue the expected result.
    task automatic step(input logic bv, input logic [LANES-1:0] tk,
                        input logic [PC_W-1:0] tgt, input logic [PC_W-1:0] ft,
                        input logic [PC_W-1:0] rc, input logic av,
                        input logic [PC_W-1:0] apc,
                        input logic [PC_W-1:0] epc, input logic [LANES-1:0] em,
                        input logic eovf, input string req);
        exp_t e;
        @(negedge clk);
        br_valid = bv; br_taken = tk; br_target = tgt;
        br_fallthru = ft; br_reconv = rc; adv_valid = av; adv_pc = apc;
        e.pc = epc; e.mask = em; e.ovf = eovf; e.req = req;
        expq.push_back(e);
    endtask

    task automatic adv(input logic [PC_W-1:0] apc, input logic [PC_W-1:0] epc,
                       input logic [LANES-1:0] em, input logic eovf, input string req);
        step(1'b0, '0, '0, '0, '0, 1'b1, apc, epc, em, eovf, req);
    endtask

    task automatic br(input logic [LANES-1:0] tk, input logic [PC_W-1:0] tgt,
                      input logic [PC_W-1:0] ft, input logic [PC_W-1:0] rc,
                      input logic [PC_W-1:0] epc, input logic [LANES-1:0] em,
                      input logic eovf, input string req);
        step(1'b1, tk, tgt, ft, rc, 1'b0, '0, epc, em, eovf, req);
    endtask

    // Monitor: pop and compare after every edge.
    always @(posedge clk) begin
        #5;
        if (expq.size() > 0) compare(expq.pop_front());
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        // R1: reset state
        r.pc = RPC0; r.mask = 4'b1111; r.ovf = 1'b0; r.req = "R1 reset";
        compare(r);
        rst_n = 1'b1;

        adv(16'h0104, 16'h0104, 4'b1111, 0, "R2 advance");
        step(0, '0, '0, '0, '0, 0, '0, 16'h0104, 4'b1111, 0, "R2 idle hold");
        // R9 and R4: a uniform taken branch wins over a simultaneous advance
        step(1, 4'b1111, 16'h0200, 16'h0108, 16'h0300, 1, 16'h0999,
             16'h0200, 4'b1111, 0, "R9 branch over advance");
        br(4'b0000, 16'h0500, 16'h0204, 16'h0300, 16'h0204, 4'b1111, 0, "R4 none taken");
        // R3: split 1100/0011, not-taken first
        br(4'b1100, 16'h0220, 16'h0208, 16'h0240, 16'h0208, 4'b0011, 0, "R3 diverge");
        // R4: taken lanes outside the active set do nothing
        br(4'b1100, 16'h0500, 16'h020C, 16'h0600, 16'h020C, 4'b0011, 0, "R4 masked lanes");
        // R5: pop to the sibling path
        adv(16'h0240, 16'h0220, 4'b1100, 0, "R5 pop to taken path");
        br(4'b0100, 16'h0230, 16'h0224, 16'h0234, 16'h0224, 4'b1000, 0, "R3 nested diverge");
        adv(16'h0234, 16'h0230, 4'b0100, 0, "R5 nested pop");
        adv(16'h0234, 16'h0234, 4'b1100, 0, "R5 inner reconverge");
        adv(16'h0238, 16'h0238, 4'b1100, 0, "R2 advance in path");
        adv(16'h0240, 16'h0240, 4'b1111, 0, "R5 outer reconverge");
        // R6: replacement when the reconvergence PCs match
        br(4'b1010, 16'h0260, 16'h0244, 16'h0280, 16'h0244, 4'b0101, 0, "R3 diverge");
        br(4'b0001, 16'h0250, 16'h0248, 16'h0280, 16'h0248, 4'b0100, 0, "R6 replace top");
        adv(16'h0280, 16'h0250, 4'b0001, 0, "R6 inner taken");
        adv(16'h0280, 16'h0260, 4'b1010, 0, "R6 outer taken");
        adv(16'h0280, 16'h0280, 4'b1111, 0, "R6 full mask");
        // R7: the taken path starts at the reconvergence PC, so only not-taken is pushed
        br(4'b0110, 16'h02A0, 16'h0284, 16'h02A0, 16'h0284, 4'b1001, 0, "R7 skip path");
        adv(16'h02A0, 16'h02A0, 4'b1111, 0, "R7 reconverge");
        // R8: overflow leaves state intact and is sticky
        br(4'b1100, 16'h0300, 16'h02A4, 16'h0400, 16'h02A4, 4'b0011, 0, "R3 diverge");
        br(4'b0010, 16'h0310, 16'h02A8, 16'h0320, 16'h02A4, 4'b0011, 1, "R8 overflow");
        adv(16'h02A8, 16'h02A8, 4'b0011, 1, "R8 sticky");
        step(0, '0, '0, '0, '0, 0, '0, 16'h02A8, 4'b0011, 1, "R8 idle sticky");
        // R1: reset clears the stack and the flag
        @(negedge clk);
        br_valid = 0; adv_valid = 0; rst_n = 0;
        r.pc = RPC0; r.mask = 4'b1111; r.ovf = 1'b0; r.req = "R1 second reset";
        expq.push_back(r);
        @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule